// File: doc/BRIEF.md
# Two-Channel Memory Mover

This block copies data between addresses on a single-master system bus. It can move memory to memory, peripheral to memory, or peripheral to peripheral. It has two independent channels. Each channel is armed by a one-cycle load pulse, which captures:
- a source address and a destination address,
- a 16-bit unit count,
- a unit size of byte, half-word or word,
- a bus-holding mode,
- a trigger source.

Every unit is moved as one read followed by one write. The data read comes back unchanged on the write. After each unit, both addresses step forward by the unit size in bytes.

The engine asks for the bus with `bus_req` and starts only after `bus_gnt`. In cycle-steal mode it releases the bus after every unit. In burst mode it keeps the bus until the channel's last unit is written. A transfer is triggered either by a software pulse, which is latched, or by a per-channel external request level.

When both channels are pending, an arbiter picks one. It uses fixed priority (channel 0 first) or round-robin (the channel just served drops to lowest). Arbitration happens only between units, and never inside a burst. Each channel raises its own interrupt on completion or on an alignment error, and each interrupt can be masked.

The read address and write data paths are valid/ready:
- `rd_valid` with its `rd_addr`/`rd_size` holds steady until `rd_ready` is seen high at a clock edge.
- The bus then returns the data with a one-cycle `rdata_valid` pulse, which the engine is always ready to take.
- `wr_valid` with `wr_addr`/`wr_size`/`wr_data` likewise holds until `wr_ready`.
- The bus may stall either handshake for any number of cycles.

Top module: `dma2ch`

## Requirements
- R1: A load whose source or destination is misaligned for its size sets that channel's error flag without starting it, and no bus cycle is made for it. Size codes: 0 byte, 1 half-word, 2 word, 3 invalid; half-word needs bit 0 clear and word needs bits 1:0 clear.
- R2: Each unit is a read at the current source followed by a write to the current destination. The write carries the read data unchanged, and both phases carry the channel's size code.
- R3: After every unit, source and destination each advance by 1, 2 or 4 bytes for size code 0, 1 or 2.
- R4: A channel performs exactly its programmed count of units, then clears busy and sets done; a count of 0 means 65,536 units.
- R5: In cycle-steal mode (`cfg_burst`=0), `bus_req` is deasserted for at least one cycle after every unit.
- R6: In burst mode (`cfg_burst`=1), `bus_req` stays asserted from the first request until the last unit of the channel is written.
- R7: With `arb_rr`=0 and both channels pending, channel 0 is served first at every decision point.
- R8: With `arb_rr`=1, a channel that was just served loses to the other channel if that one is pending.
- R9: A channel with `cfg_ext`=0 starts on a one-cycle `sw_req` pulse. A channel with `cfg_ext`=1 moves units only while its `ext_req` is high, and ignores `sw_req`.
- R10: `irq[i]` is high when channel i is done or in error and `irq_mask[i]` is 0. It is cleared by the next accepted load.
- R11: `rd_valid` and `wr_valid` with their address and data hold until accepted by the matching ready, and no read is issued before `bus_gnt`.
- R12: A load pulse to a channel that is still busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| arb_rr | input | 1 | 1 = round-robin, 0 = fixed priority |
| cfg_load | input | 2 | Per-channel load pulse |
| cfg_src | input | 2x32 | Source start address |
| cfg_dst | input | 2x32 | Destination start address |
| cfg_count | input | 2x16 | Unit count, 0 = 65,536 |
| cfg_size | input | 2x2 | Size code |
| cfg_burst | input | 2 | 1 = burst, 0 = cycle-steal |
| cfg_ext | input | 2 | 1 = external trigger, 0 = software trigger |
| sw_req | input | 2 | Software start pulse |
| ext_req | input | 2 | External request level |
| irq_mask | input | 2 | 1 masks the channel interrupt |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| rd_valid | output | 1 | Read address valid |
| rd_ready | input | 1 | Read address accepted |
| rd_addr | output | 32 | Read address |
| rd_size | output | 2 | Read size code |
| rdata_valid | input | 1 | Read data pulse |
| rdata | input | 32 | Read data |
| wr_valid | output | 1 | Write valid |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | 32 | Write address |
| wr_size | output | 2 | Write size code |
| wr_data | output | 32 | Write data |
| ch_busy | output | 2 | Channel armed and not finished |
| ch_done | output | 2 | Count completed |
| ch_err | output | 2 | Alignment error |
| irq | output | 2 | Masked interrupt |

## Verification
The hardest situations to reach are the arbitration decisions. They need both channels pending at the same idle cycle. The bench does this by arming both channels and starting them with a single two-bit software pulse, so every later decision point sees both requests. The run is done once in fixed and once in round-robin mode, and the bench checks the order of channels in the logged read addresses.

A count of 0 cannot be run to its end within the cycle budget. It is driven through the external trigger instead: the trigger is removed after twenty units, and the bench checks that the channel is still busy and not done. The bus model throughout stalls grant, both readies and read data at random, so the hold rules are exercised on every unit.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int NCH = 2;

  typedef enum logic [2:0] {
    E_IDLE,
    E_REQ,
    E_RD,
    E_RWT,
    E_WR
  } eng_st_t;

  function automatic logic [2:0] unit_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    unit_bytes = 3'd1;
      2'd1:    unit_bytes = 3'd2;
      default: unit_bytes = 3'd4;
    endcase
  endfunction

  function automatic logic bad_align(input logic [1:0] lo, input logic [1:0] sz);
    case (sz)
      2'd0:    bad_align = 1'b0;
      2'd1:    bad_align = lo[0];
      2'd2:    bad_align = |lo;
      default: bad_align = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [1:0]    size_i,
  input  logic          burst_i,
  input  logic          ext_i,
  input  logic          sw_req,
  input  logic          ext_req,
  input  logic          adv,
  output logic          pend,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [1:0]    size_o,
  output logic          burst_o,
  output logic          last_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o
);
  logic          act, go, ext_q;
  logic [CW-1:0] cnt;
  logic [AW-1:0] step;

  assign step = AW'(unit_bytes(size_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0; go <= 1'b0; ext_q <= 1'b0; cnt <= '0;
      src_o <= '0; dst_o <= '0; size_o <= '0; burst_o <= 1'b0;
      done_o <= 1'b0; err_o <= 1'b0;
    end else if (load && !act) begin
      // R12: only an idle channel accepts a new load
      src_o <= src_i; dst_o <= dst_i; cnt <= cnt_i;
      size_o <= size_i; burst_o <= burst_i; ext_q <= ext_i;
      done_o <= 1'b0; go <= 1'b0;
      if (bad_align(src_i[1:0], size_i) || bad_align(dst_i[1:0], size_i)) begin
        err_o <= 1'b1; act <= 1'b0;   // R1
      end else begin
        err_o <= 1'b0; act <= 1'b1;
      end
    end else if (act) begin
      if (sw_req && !ext_q) go <= 1'b1;   // R9
      if (adv) begin
        src_o <= src_o + step;            // R3
        dst_o <= dst_o + step;
        cnt   <= cnt - 1'b1;              // 0 wraps: 65,536 units (R4)
        if (last_o) begin
          act <= 1'b0; done_o <= 1'b1; go <= 1'b0;
        end
      end
    end
  end

  assign last_o = (cnt == CW'(1));
  assign busy_o = act;
  assign pend   = act && (ext_q ? ext_req : go);
endmodule

// File: rtl/dma_arb.sv
module dma_arb (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rr_mode,
  input  logic [1:0] pend,
  input  logic       take,
  output logic       win,
  output logic       any
);
  logic last_q;

  always_comb begin
    if (&pend) win = rr_mode ? ~last_q : 1'b0;   // R8 / R7
    else       win = pend[1];
  end
  assign any = |pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    last_q <= 1'b1;
    else if (take) last_q <= win;
  end
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    any,
  input  logic                    win,
  input  logic [NCH-1:0][AW-1:0]  ch_src,
  input  logic [NCH-1:0][AW-1:0]  ch_dst,
  input  logic [NCH-1:0][1:0]     ch_size,
  input  logic [NCH-1:0]          ch_burst,
  input  logic [NCH-1:0]          ch_last,
  output logic                    take,
  output logic [NCH-1:0]          adv,
  output logic                    sel,
  output logic                    bus_req,
  input  logic                    bus_gnt,
  output logic                    rd_valid,
  input  logic                    rd_ready,
  output logic [AW-1:0]           rd_addr,
  output logic [1:0]              rd_size,
  input  logic                    rdata_valid,
  input  logic [DW-1:0]           rdata,
  output logic                    wr_valid,
  input  logic                    wr_ready,
  output logic [AW-1:0]           wr_addr,
  output logic [1:0]              wr_size,
  output logic [DW-1:0]           wr_data
);
  eng_st_t       st;
  logic [DW-1:0] data_q;
  logic          wr_done;

  assign wr_done = (st == E_WR) && wr_ready;
  assign take    = (st == E_IDLE) && any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= E_IDLE; sel <= 1'b0; data_q <= '0;
    end else begin
      case (st)
        E_IDLE: if (any) begin sel <= win; st <= E_REQ; end
        E_REQ:  if (bus_gnt) st <= E_RD;
        E_RD:   if (rd_ready) st <= E_RWT;
        E_RWT:  if (rdata_valid) begin data_q <= rdata; st <= E_WR; end
        E_WR:   if (wr_ready)
                  st <= (ch_burst[sel] && !ch_last[sel]) ? E_RD : E_IDLE;  // R6 / R5
        default: st <= E_IDLE;
      endcase
    end
  end

  always_comb begin
    adv = '0;
    adv[sel] = wr_done;
  end

  assign bus_req  = (st != E_IDLE);
  assign rd_valid = (st == E_RD);
  assign rd_addr  = ch_src[sel];
  assign rd_size  = ch_size[sel];
  assign wr_valid = (st == E_WR);
  assign wr_addr  = ch_dst[sel];
  assign wr_size  = ch_size[sel];
  assign wr_data  = data_q;
endmodule

// File: rtl/dma2ch.sv
module dma2ch
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   arb_rr,
  input  logic [NCH-1:0]         cfg_load,
  input  logic [NCH-1:0][AW-1:0] cfg_src,
  input  logic [NCH-1:0][AW-1:0] cfg_dst,
  input  logic [NCH-1:0][CW-1:0] cfg_count,
  input  logic [NCH-1:0][1:0]    cfg_size,
  input  logic [NCH-1:0]         cfg_burst,
  input  logic [NCH-1:0]         cfg_ext,
  input  logic [NCH-1:0]         sw_req,
  input  logic [NCH-1:0]         ext_req,
  input  logic [NCH-1:0]         irq_mask,
  output logic                   bus_req,
  input  logic                   bus_gnt,
  output logic                   rd_valid,
  input  logic                   rd_ready,
  output logic [AW-1:0]          rd_addr,
  output logic [1:0]             rd_size,
  input  logic                   rdata_valid,
  input  logic [DW-1:0]          rdata,
  output logic                   wr_valid,
  input  logic                   wr_ready,
  output logic [AW-1:0]          wr_addr,
  output logic [1:0]             wr_size,
  output logic [DW-1:0]          wr_data,
  output logic [NCH-1:0]         ch_busy,
  output logic [NCH-1:0]         ch_done,
  output logic [NCH-1:0]         ch_err,
  output logic [NCH-1:0]         irq
);
  logic [NCH-1:0]         pend, burst_v, last_v, adv;
  logic [NCH-1:0][AW-1:0] src_v, dst_v;
  logic [NCH-1:0][1:0]    size_v;
  logic                   win, any, take, sel;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dma_chan #(.AW(AW), .CW(CW)) u_chan (
      .clk(clk), .rst_n(rst_n), .load(cfg_load[i]),
      .src_i(cfg_src[i]), .dst_i(cfg_dst[i]), .cnt_i(cfg_count[i]),
      .size_i(cfg_size[i]), .burst_i(cfg_burst[i]), .ext_i(cfg_ext[i]),
      .sw_req(sw_req[i]), .ext_req(ext_req[i]), .adv(adv[i]),
      .pend(pend[i]), .src_o(src_v[i]), .dst_o(dst_v[i]), .size_o(size_v[i]),
      .burst_o(burst_v[i]), .last_o(last_v[i]), .busy_o(ch_busy[i]),
      .done_o(ch_done[i]), .err_o(ch_err[i])
    );
  end

  dma_arb u_arb (
    .clk(clk), .rst_n(rst_n), .rr_mode(arb_rr), .pend(pend),
    .take(take), .win(win), .any(any)
  );

  dma_engine #(.AW(AW), .DW(DW)) u_eng (
    .clk(clk), .rst_n(rst_n), .any(any), .win(win),
    .ch_src(src_v), .ch_dst(dst_v), .ch_size(size_v),
    .ch_burst(burst_v), .ch_last(last_v),
    .take(take), .adv(adv), .sel(sel),
    .bus_req(bus_req), .bus_gnt(bus_gnt),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_size(rd_size),
    .rdata_valid(rdata_valid), .rdata(rdata),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_size(wr_size), .wr_data(wr_data)
  );

  assign irq = (ch_done | ch_err) & ~irq_mask;   // R10
endmodule

// File: rtl/dma2ch_chk.sv
module dma2ch_chk
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [AW-1:0] rd_addr,
  input logic [1:0]    rd_size,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [1:0]    wr_size,
  input logic [DW-1:0] wr_data,
  input logic          own_burst,
  input logic          own_last
);
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr) && $stable(rd_size));

  p_wr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  p_no_early_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> !rd_valid);

  p_rd_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !bad_align(rd_addr[1:0], rd_size));

  p_wr_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !bad_align(wr_addr[1:0], wr_size));

  p_steal_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && !own_burst |=> !bus_req);

  p_burst_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && own_burst && !own_last |=> bus_req && rd_valid);
endmodule

bind dma2ch dma2ch_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_size(rd_size),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_size(wr_size),
  .wr_data(wr_data), .own_burst(burst_v[sel]), .own_last(last_v[sel])
);

// File: tb/test_dma2ch.sv
`timescale 1ns/1ps
module test_dma2ch;
  logic              clk = 1'b0, rst_n = 1'b0, arb_rr = 1'b0;
  logic [1:0]        cfg_load = '0, cfg_burst = '0, cfg_ext = '0;
  logic [1:0]        sw_req = '0, ext_req = '0, irq_mask = '0;
  logic [1:0][31:0]  cfg_src = '0, cfg_dst = '0;
  logic [1:0][15:0]  cfg_count = '0;
  logic [1:0][1:0]   cfg_size = '0;
  logic              bus_req, bus_gnt = 1'b0, rd_valid, rd_ready = 1'b0;
  logic [31:0]       rd_addr, wr_addr, wr_data, rdata = '0;
  logic [1:0]        rd_size, wr_size, ch_busy, ch_done, ch_err, irq;
  logic              rdata_valid = 1'b0, wr_valid, wr_ready = 1'b0;

  dma2ch i_dma2ch (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_err = 0;
  int lg_n = 0, lr_n = 0, falls = 0;
  logic [31:0] lg_rd [256];
  logic [31:0] lg_wr [256];
  logic [31:0] lg_dat [256];
  logic [1:0]  lg_sz [256];
  logic        rd_out = 1'b0, prev_req = 1'b0;
  logic [31:0] rd_out_addr = '0;

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
  endfunction

  function automatic logic [31:0] stepf(input logic [1:0] s);
    return (s == 2'd0) ? 32'd1 : (s == 2'd1) ? 32'd2 : 32'd4;
  endfunction

  // Bus model: random stalls on grant, both readies and read data
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_gnt = 1'b0; rd_ready = 1'b0; wr_ready = 1'b0; rdata_valid = 1'b0; rd_out = 1'b0;
    end else begin
      if (prev_req && !bus_req) falls++;
      prev_req = bus_req;
      bus_gnt = bus_req && (bus_gnt || ($urandom_range(0, 2) == 0));
      if (rdata_valid) rdata_valid = 1'b0;
      else if (rd_out && $urandom_range(0, 1) == 1) begin
        rdata_valid = 1'b1; rdata = memf(rd_out_addr); rd_out = 1'b0;
      end
      rd_ready = rd_valid && ($urandom_range(0, 1) == 1);
      if (rd_valid && rd_ready) begin
        rd_out = 1'b1; rd_out_addr = rd_addr;
        if (lr_n < 256) lg_rd[lr_n] = rd_addr;
        lr_n++;
      end
      wr_ready = wr_valid && ($urandom_range(0, 1) == 1);
      if (wr_valid && wr_ready) begin
        if (lg_n < 256) begin
          lg_wr[lg_n] = wr_addr; lg_dat[lg_n] = wr_data; lg_sz[lg_n] = wr_size;
        end
        lg_n++;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clr();
    @(negedge clk); lg_n = 0; lr_n = 0; falls = 0;
  endtask

  task automatic load(input int ch, input logic [31:0] s, input logic [31:0] d,
                      input logic [15:0] c, input logic [1:0] z, input logic b, input logic e);
    @(negedge clk);
    cfg_src[ch] = s; cfg_dst[ch] = d; cfg_count[ch] = c; cfg_size[ch] = z;
    cfg_burst[ch] = b; cfg_ext[ch] = e; cfg_load[ch] = 1'b1;
    @(negedge clk); cfg_load = '0;
  endtask

  task automatic go(input logic [1:0] m);
    @(negedge clk); sw_req = m;
    @(negedge clk); sw_req = '0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (ch_busy == 2'b00 && !bus_req) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_run(input string req, input int base, input logic [31:0] s,
                         input logic [31:0] d, input int cnt, input logic [1:0] z);
    for (int k = 0; k < cnt; k++) begin
      check({req, " rd addr"}, lg_rd[base+k], s + stepf(z) * k);
      check({req, " wr addr"}, lg_wr[base+k], d + stepf(z) * k);
      check({req, " data"}, lg_dat[base+k], memf(s + stepf(z) * k));
      check({req, " size"}, {30'd0, lg_sz[base+k]}, {30'd0, z});
    end
  endtask

  initial begin
    #1500000;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R4 reset busy", {30'd0, ch_busy}, 32'd0);
    check("R10 reset irq", {30'd0, irq}, 32'd0);
    check("R11 reset bus_req", {31'd0, bus_req}, 32'd0);

    // R2 R3 R4 R5: word, cycle-steal, software start
    clr(); load(0, 32'h0000_1000, 32'h0000_2000, 16'd3, 2'd2, 1'b0, 1'b0);
    go(2'b01); wait_idle();
    check("R4 count", lg_n, 3);
    chk_run("R2 R3", 0, 32'h1000, 32'h2000, 3, 2'd2);
    check("R5 releases", falls, 3);
    check("R4 done", {30'd0, ch_done}, 32'd1);
    check("R10 irq", {30'd0, irq}, 32'd1);

    // R6: burst half-word on channel 1
    clr(); load(1, 32'h0000_3002, 32'h0000_4006, 16'd4, 2'd1, 1'b1, 1'b0);
    go(2'b10); wait_idle();
    check("R4 count burst", lg_n, 4);
    chk_run("R3 half", 0, 32'h3002, 32'h4006, 4, 2'd1);
    check("R6 single release", falls, 1);

    // R1: misaligned word and invalid size
    clr(); load(0, 32'h0000_1002, 32'h0000_2000, 16'd2, 2'd2, 1'b0, 1'b0);
    go(2'b01); repeat (20) @(negedge clk);
    check("R1 err", {31'd0, ch_err[0]}, 32'd1);
    check("R1 no bus", lg_n + lr_n, 0);
    check("R1 not busy", {31'd0, ch_busy[0]}, 32'd0);
    check("R10 err irq", {31'd0, irq[0]}, 32'd1);
    irq_mask = 2'b01; #1;
    check("R10 masked", {31'd0, irq[0]}, 32'd0);
    irq_mask = 2'b00;
    load(1, 32'h0000_3000, 32'h0000_4000, 16'd2, 2'd3, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    check("R1 size3 err", {31'd0, ch_err[1]}, 32'd1);
    load(0, 32'h0000_1000, 32'h0000_2000, 16'd1, 2'd0, 1'b0, 1'b1);
    check("R10 load clears", {31'd0, irq[0]}, 32'd0);
    check("R1 load clears err", {31'd0, ch_err[0]}, 32'd0);
    ext_req[0] = 1'b1; wait_idle(); ext_req[0] = 1'b0;

    // R7: fixed priority
    arb_rr = 1'b0;
    load(0, 32'h0000_1000, 32'h0000_2000, 16'd2, 2'd2, 1'b0, 1'b0);
    load(1, 32'h0000_3000, 32'h0000_4000, 16'd2, 2'd2, 1'b0, 1'b0);
    clr(); go(2'b11); wait_idle();
    check("R7 order0", lg_rd[0], 32'h1000);
    check("R7 order1", lg_rd[1], 32'h1004);
    check("R7 order2", lg_rd[2], 32'h3000);
    check("R7 order3", lg_rd[3], 32'h3004);

    // R8: round-robin
    arb_rr = 1'b1;
    load(0, 32'h0000_1000, 32'h0000_2000, 16'd2, 2'd2, 1'b0, 1'b0);
    load(1, 32'h0000_3000, 32'h0000_4000, 16'd2, 2'd2, 1'b0, 1'b0);
    clr(); go(2'b11); wait_idle();
    check("R8 order0", lg_rd[0], 32'h1000);
    check("R8 order1", lg_rd[1], 32'h3000);
    check("R8 order2", lg_rd[2], 32'h1004);
    check("R8 order3", lg_rd[3], 32'h3004);
    arb_rr = 1'b0;

    // R9: external trigger, software pulse ignored
    clr(); load(1, 32'h0000_5000, 32'h0000_6000, 16'd2, 2'd1, 1'b0, 1'b1);
    go(2'b10); repeat (40) @(negedge clk);
    check("R9 waits ext", lg_n + lr_n, 0);
    check("R9 still busy", {31'd0, ch_busy[1]}, 32'd1);
    ext_req[1] = 1'b1; wait_idle(); ext_req[1] = 1'b0;
    chk_run("R9 ext run", 0, 32'h5000, 32'h6000, 2, 2'd1);

    // R12: load while busy ignored
    clr(); load(0, 32'h0000_7000, 32'h0000_7800, 16'd2, 2'd2, 1'b0, 1'b1);
    load(0, 32'h0000_9000, 32'h0000_9800, 16'd5, 2'd0, 1'b0, 1'b1);
    ext_req[0] = 1'b1; wait_idle(); ext_req[0] = 1'b0;
    check("R12 count kept", lg_n, 2);
    chk_run("R12 addr kept", 0, 32'h7000, 32'h7800, 2, 2'd2);

    // Random rounds, mixed modes
    for (int r = 0; r < 12; r++) begin
      int ch, cnt;
      logic [1:0] z;
      logic b;
      logic [31:0] s, d;
      ch = $urandom_range(0, 1); z = 2'($urandom_range(0, 2));
      cnt = $urandom_range(1, 6); b = 1'($urandom_range(0, 1));
      s = 32'h0001_0000 | ($urandom & 32'h0000_FFF0);
      d = 32'h0008_0000 | ($urandom & 32'h0000_FFF0);
      clr(); load(ch, s, d, 16'(cnt), z, b, 1'b0);
      go(ch == 0 ? 2'b01 : 2'b10); wait_idle();
      check("R4 rand count", lg_n, cnt);
      chk_run("R2 R3 rand", 0, s, d, cnt, z);
      check(b ? "R6 rand hold" : "R5 rand release", falls, b ? 1 : cnt);
      check("R10 rand irq", {31'd0, irq[ch]}, 32'd1);
    end

    // R4: count 0 means 65,536 units
    clr(); load(1, 32'h0002_0000, 32'h0003_0000, 16'd0, 2'd0, 1'b0, 1'b1);
    ext_req[1] = 1'b1;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (lg_n >= 20) break;
    end
    ext_req[1] = 1'b0;
    repeat (30) @(negedge clk);
    check("R4 zero still busy", {31'd0, ch_busy[1]}, 32'd1);
    check("R4 zero not done", {31'd0, ch_done[1]}, 32'd0);
    chk_run("R4 zero run", 0, 32'h0002_0000, 32'h0003_0000, 20, 2'd0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule